// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Software Override

This block sits between a PWM time base and the two output pins of a PWM channel pair, A and B. On every time-base tick it looks at which events occurred: the counter at zero, the counter at the shared period, and the counter equal to either of two compare values while counting up. It then applies the action programmed for the highest-priority event to each output level. Each event has a 2-bit action per output: no action, drive low, drive high or toggle.

A continuous software override sits on top of each output. Software writes an override code into a staging register. A copy of that register becomes active under a selectable reload policy: at a zero tick, at a period tick, at either one, or at the very next tick. While an override is active it pins the output high or low. The event-driven level keeps running underneath it, so releasing the override returns the pin to the level the events would have produced.

All settings (two compare values, two action words, the reload policy and the override word) are written through a single-cycle register write port.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, every register (compares, action words, reload policy, override staging and active override) is zero, and no override is active.
- R2: An action code is 00 none, 01 drive low, 10 drive high, 11 toggle. The event-driven level changes only on a cycle with `tb_tick` high, and event strobes and compare matches have no effect on cycles without a tick.
- R3: Within an action word, the zero-event action sits in bits 1:0, the period-event action in bits 3:2, the compare-A action in bits 5:4 and the compare-B action in bits 9:8. Compare matches count only while `tb_up` is high.
- R4: A compare-A match is `tb_cnt` equal to the register at address 0, and a compare-B match is `tb_cnt` equal to the register at address 1. Both outputs share the one time base and its period event.
- R5: When several events occur on one tick, compare B wins over compare A, which wins over the period event, which wins over the zero event. An event whose action is 00 does not hide a lower-priority event.
- R6: Action word 0x01A on output A (and 0x10A on output B) gives high from zero until the compare match, then low. Action word 0x025 gives the inverted waveform.
- R7: The override word holds output A's code in bits 1:0 and output B's code in bits 3:2. Code 01 forces the pin low and code 10 forces it high. Codes 00 and 11 disable the override.
- R8: Reload policy (bits 1:0 at address 4) copies the staging override into the active override on a tick with a zero event (00), a tick with a period event (01), a tick with either event (10), or the next tick of any kind (11). No copy happens on cycles without a tick.
- R9: While overridden, an output's event-driven level keeps updating. When the override is released, the pin shows that level.
- R10: The register map is 0 compare A, 1 compare B, 2 action A, 3 action B, 4 reload policy, 5 override staging. A write to addresses 6 or 7 changes nothing. A register written on the same cycle as a tick takes effect from the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Time-base tick; events are evaluated only on this cycle |
| tb_cnt | input | CNT_W | Time-base counter value |
| tb_zero | input | 1 | Counter-at-zero strobe |
| tb_prd | input | 1 | Counter-at-period strobe |
| tb_up | input | 1 | Counter is counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |

## Verification
The outputs are exercised with up-counting periods using normal and inverted action words. These show whether each compare register drives the correct output and whether the polarity mapping is right. Toggle-only words and ticks spaced between idle cycles separate tick-gated updates from updates that leak on every clock. Coincident events at count zero and at the period set the priority order against itself, and a down-counting run shows whether compares are wrongly honoured. The override runs walk each reload policy with ticks that fall both on and off the zero and period events, so an early or missing copy from staging to active shows up as a pin mismatch. A release then checks that the pin follows the level the events kept producing underneath the override.

// File: rtl/aq_pkg.sv
package aq_pkg;
   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      RLD_ZERO = 2'b00,
      RLD_PRD  = 2'b01,
      RLD_BOTH = 2'b10,
      RLD_NOW  = 2'b11
   } rld_e;

   localparam logic [1:0] FRC_LOW  = 2'b01;
   localparam logic [1:0] FRC_HIGH = 2'b10;

   // action word field positions
   localparam int ZRO_LSB = 0;
   localparam int PRD_LSB = 2;
   localparam int CAU_LSB = 4;
   localparam int CBU_LSB = 8;
   localparam int ACT_W   = 10;

   localparam int NUM_CH  = 2;

   // register map
   localparam int ADR_CMPA = 0;
   localparam int ADR_CMPB = 1;
   localparam int ADR_ACTA = 2;
   localparam int ADR_ACTB = 3;
   localparam int ADR_RLD  = 4;
   localparam int ADR_FRC  = 5;
endpackage

// File: rtl/aq_regfile.sv
module aq_regfile
   import aq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_CH-1:0][CNT_W-1:0]       cmp_val,
   output logic [NUM_CH-1:0][ACT_W-1:0]       act_word,
   output logic [1:0]                         rld_sel,
   output logic [NUM_CH-1:0][1:0]             frc_shd
);
   localparam int FRC_W = 2 * NUM_CH;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val  <= '0;
         act_word <= '0;
         rld_sel  <= '0;
         frc_shd  <= '0;
      end else if (wr_en) begin
         case (int'(wr_addr))
            ADR_CMPA: cmp_val[0]  <= wr_data[CNT_W-1:0];
            ADR_CMPB: cmp_val[1]  <= wr_data[CNT_W-1:0];
            ADR_ACTA: act_word[0] <= wr_data[ACT_W-1:0];
            ADR_ACTB: act_word[1] <= wr_data[ACT_W-1:0];
            ADR_RLD:  rld_sel     <= wr_data[1:0];
            ADR_FRC:  frc_shd     <= wr_data[FRC_W-1:0];
            default: ;
         endcase
      end
   end

   assert_cmpa_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == ADR_CMPA) |=> cmp_val[0] == $past(wr_data[CNT_W-1:0]));

   assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) > ADR_FRC) |=>
         ($stable(cmp_val) && $stable(act_word) && $stable(rld_sel) && $stable(frc_shd)));
endmodule

// File: rtl/aq_cmp_match.sv
module aq_cmp_match #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             up,
   output logic             hit
);
   assign hit = up && (cnt == cmp);
endmodule

// File: rtl/aq_channel.sv
module aq_channel
   import aq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ev_zero,
   input  logic             ev_prd,
   input  logic             ev_cau,
   input  logic             ev_cbu,
   input  logic [ACT_W-1:0] act_word,
   output logic             lvl
);
   act_e a_z, a_p, a_ca, a_cb, win;
   logic nxt;

   assign a_z  = act_e'(act_word[ZRO_LSB +: 2]);
   assign a_p  = act_e'(act_word[PRD_LSB +: 2]);
   assign a_ca = act_e'(act_word[CAU_LSB +: 2]);
   assign a_cb = act_e'(act_word[CBU_LSB +: 2]);

   // lowest priority first; later assignments override
   always_comb begin
      win = ACT_NONE;
      if (ev_zero && a_z  != ACT_NONE) win = a_z;
      if (ev_prd  && a_p  != ACT_NONE) win = a_p;
      if (ev_cau  && a_ca != ACT_NONE) win = a_ca;
      if (ev_cbu  && a_cb != ACT_NONE) win = a_cb;
   end

   always_comb begin
      case (win)
         ACT_LOW:    nxt = 1'b0;
         ACT_HIGH:   nxt = 1'b1;
         ACT_TOGGLE: nxt = ~lvl;
         default:    nxt = lvl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    lvl <= 1'b0;
      else if (tick) lvl <= nxt;
   end

   assert_hold_off_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl));

   assert_cbu_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ev_cbu && a_cb == ACT_HIGH) |=> lvl);

   assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ev_zero && !ev_prd && !ev_cau && !ev_cbu && a_z == ACT_TOGGLE)
         |=> lvl != $past(lvl));
endmodule

// File: rtl/aq_force.sv
module aq_force
   import aq_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   ev_zero,
   input  logic                   ev_prd,
   input  logic [1:0]             rld_sel,
   input  logic [NUM_CH-1:0][1:0] frc_shd,
   output logic [NUM_CH-1:0][1:0] frc_act
);
   logic load;

   always_comb begin
      case (rld_e'(rld_sel))
         RLD_ZERO: load = tick && ev_zero;
         RLD_PRD:  load = tick && ev_prd;
         RLD_BOTH: load = tick && (ev_zero || ev_prd);
         default:  load = tick;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    frc_act <= '0;
      else if (load) frc_act <= frc_shd;
   end

   assert_no_copy_off_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(frc_act));

   assert_zero_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_e'(rld_sel) == RLD_ZERO && !ev_zero) |=> $stable(frc_act));

   assert_now_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rld_e'(rld_sel) == RLD_NOW) |=> frc_act == $past(frc_shd));
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
   import aq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tb_tick,
   input  logic [CNT_W-1:0]  tb_cnt,
   input  logic              tb_zero,
   input  logic              tb_prd,
   input  logic              tb_up,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_a,
   output logic              pwm_b
);
   localparam int MIN_DATA_W = (CNT_W > ACT_W) ? CNT_W : ACT_W;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      $error("DATA_W must hold a compare value and an action word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must reach six registers");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cmp_val;
   logic [NUM_CH-1:0][ACT_W-1:0] act_word;
   logic [1:0]                   rld_sel;
   logic [NUM_CH-1:0][1:0]       frc_shd;
   logic [NUM_CH-1:0][1:0]       frc_act;
   logic [NUM_CH-1:0]            hit;
   logic [NUM_CH-1:0]            lvl;
   logic [NUM_CH-1:0]            pin;

   aq_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cmp_val  (cmp_val),
      .act_word (act_word),
      .rld_sel  (rld_sel),
      .frc_shd  (frc_shd)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
      aq_cmp_match #(.CNT_W(CNT_W)) u_match (
         .cnt (tb_cnt),
         .cmp (cmp_val[k]),
         .up  (tb_up),
         .hit (hit[k])
      );
   end

   aq_force u_force (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tb_tick),
      .ev_zero (tb_zero),
      .ev_prd  (tb_prd),
      .rld_sel (rld_sel),
      .frc_shd (frc_shd),
      .frc_act (frc_act)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      aq_channel u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tb_tick),
         .ev_zero  (tb_zero),
         .ev_prd   (tb_prd),
         .ev_cau   (hit[0]),
         .ev_cbu   (hit[1]),
         .act_word (act_word[c]),
         .lvl      (lvl[c])
      );

      assign pin[c] = (frc_act[c] == FRC_HIGH) ? 1'b1 :
                      (frc_act[c] == FRC_LOW)  ? 1'b0 : lvl[c];

      assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (frc_act[c] == FRC_LOW) |-> !pin[c]);

      assert_force_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (frc_act[c] == FRC_HIGH) |-> pin[c]);
   end

   assign pwm_a = pin[0];
   assign pwm_b = pin[1];

   assert_reset_low_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/tb_pwm_action_qual.sv
module tb_pwm_action_qual;
   localparam int CNT_W = 16, DATA_W = 16, ADDR_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tb_tick = 0, tb_zero = 0, tb_prd = 0, tb_up = 0, wr_en = 0;
   logic [CNT_W-1:0]  tb_cnt = '0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic pwm_a, pwm_b;

   always #2 clk = ~clk;

   pwm_action_qual #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_cnt(tb_cnt),
      .tb_zero(tb_zero), .tb_prd(tb_prd), .tb_up(tb_up),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   typedef struct {
      logic  a;
      logic  b;
      string req;
   } exp_t;

   exp_t  q[$];
   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // reference model state
   int       m_cmp[2];
   bit [9:0] m_act[2];
   bit [1:0] m_sel;
   bit [1:0] m_fsh[2];
   bit [1:0] m_fact[2];
   bit       m_lvl[2];

   function automatic bit m_out(int ch);
      if (m_fact[ch] == 2'b01) return 1'b0;
      if (m_fact[ch] == 2'b10) return 1'b1;
      return m_lvl[ch];
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // driver: one clock of stimulus plus the expected pins after that edge
   task automatic cyc(input bit tk, input int cv, input bit z, input bit p, input bit up,
                      input bit we = 0, input int ad = 0, input int dt = 0);
      exp_t e;
      bit ca, cb, ld;
      @(negedge clk);
      tb_tick = tk; tb_cnt = cv[CNT_W-1:0]; tb_zero = z; tb_prd = p; tb_up = up;
      wr_en = we; wr_addr = ad[ADDR_W-1:0]; wr_data = dt[DATA_W-1:0];
      if (tk) begin
         ca = up && (cv == m_cmp[0]);
         cb = up && (cv == m_cmp[1]);
         for (int ch = 0; ch < 2; ch++) begin
            bit [1:0] w = 2'b00;
            if (z  && m_act[ch][1:0] != 0) w = m_act[ch][1:0];
            if (p  && m_act[ch][3:2] != 0) w = m_act[ch][3:2];
            if (ca && m_act[ch][5:4] != 0) w = m_act[ch][5:4];
            if (cb && m_act[ch][9:8] != 0) w = m_act[ch][9:8];
            case (w)
               2'b01: m_lvl[ch] = 1'b0;
               2'b10: m_lvl[ch] = 1'b1;
               2'b11: m_lvl[ch] = ~m_lvl[ch];
               default: ;
            endcase
         end
         case (m_sel)
            2'b00: ld = z;
            2'b01: ld = p;
            2'b10: ld = z || p;
            default: ld = 1'b1;
         endcase
         if (ld) begin
            m_fact[0] = m_fsh[0];
            m_fact[1] = m_fsh[1];
         end
      end
      if (we) begin
         case (ad)
            0: m_cmp[0] = dt;
            1: m_cmp[1] = dt;
            2: m_act[0] = dt[9:0];
            3: m_act[1] = dt[9:0];
            4: m_sel    = dt[1:0];
            5: begin m_fsh[0] = dt[1:0]; m_fsh[1] = dt[3:2]; end
            default: ;
         endcase
      end
      e.a = m_out(0); e.b = m_out(1); e.req = cur_req;
      q.push_back(e);
   endtask

   task automatic wr(input int ad, input int dt);
      cyc(0, 0, 0, 0, 1, 1, ad, dt);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
   endtask

   // up or down counting periods, idle cycles holding strobes between ticks
   task automatic run(input int prd, input int nper, input bit up, input int gap);
      for (int k = 0; k < nper; k++) begin
         for (int c = 0; c <= prd; c++) begin
            int cv = up ? c : prd - c;
            cyc(1, cv, cv == 0, cv == prd, up);
            for (int g = 0; g < gap; g++) cyc(0, cv, cv == 0, cv == prd, up);
         end
      end
   endtask

   // monitor: compare pins one time unit after each rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (pwm_a !== e.a || pwm_b !== e.b) begin
               n_bad++;
               $display("FAIL %s: got a=%b b=%b expected a=%b b=%b",
                        e.req, pwm_a, pwm_b, e.a, e.b);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      summary();
   end

   initial begin
      for (int ch = 0; ch < 2; ch++) begin
         m_cmp[ch] = 0; m_act[ch] = 0; m_fsh[ch] = 0; m_fact[ch] = 0; m_lvl[ch] = 0;
      end
      m_sel = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: pins low out of reset
      n_cmp++;
      if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: got a=%b b=%b expected a=0 b=0", pwm_a, pwm_b);
      end
      cur_req = "R1"; run(5, 1, 1'b1, 0);          // zero action words: still low

      // R4 / R6: normal polarity, compare A on A, compare B on B
      cur_req = "R10"; wr(0, 3); wr(1, 5); wr(2, 'h01A); wr(3, 'h10A);
      cur_req = "R6";  run(7, 3, 1'b1, 1);
      cur_req = "R4";  wr(0, 6); run(7, 2, 1'b1, 0);

      // R6: inverted polarity on A
      cur_req = "R6"; wr(2, 'h025); run(7, 2, 1'b1, 0);

      // R2: toggle on zero only, no action on B, ticks spaced by idle cycles
      cur_req = "R2"; wr(2, 'h003); wr(3, 'h000); run(3, 4, 1'b1, 2);
      cur_req = "R2"; wr(2, 'h00C); run(3, 3, 1'b1, 0);

      // R5: coincident events
      cur_req = "R5"; wr(0, 0); wr(1, 0); wr(2, 'h212); wr(3, 'h012);
      run(4, 2, 1'b1, 0);
      cur_req = "R5"; wr(2, 'h012); wr(3, 'h20A); run(4, 2, 1'b1, 0);
      cur_req = "R5"; wr(0, 4); wr(2, 'h01C); run(4, 2, 1'b1, 0);

      // R3: compares ignored while counting down
      cur_req = "R3"; wr(0, 2); wr(1, 3); wr(2, 'h020); wr(3, 'h300);
      run(5, 2, 1'b0, 0);
      cur_req = "R3"; run(5, 1, 1'b1, 0);

      // R7 / R8: overrides under each reload policy
      cur_req = "R7"; wr(0, 3); wr(1, 5); wr(2, 'h01A); wr(3, 'h10A);
      wr(4, 0); wr(5, 'h6); idle(3);
      cur_req = "R8"; run(6, 2, 1'b1, 1);
      cur_req = "R7"; wr(5, 'hF); run(6, 1, 1'b1, 0);
      cur_req = "R8"; wr(4, 1); wr(5, 'h9); run(6, 2, 1'b1, 1);
      cur_req = "R8"; wr(4, 2); wr(5, 'h6); run(6, 2, 1'b1, 2);
      cur_req = "R8"; wr(4, 3); wr(5, 'h9); idle(4);
      cyc(1, 2, 0, 0, 1); idle(2);

      // R9: release returns to event-driven level
      cur_req = "R9"; run(6, 1, 1'b1, 0); wr(5, 'h0);
      cyc(1, 1, 0, 0, 1); run(6, 2, 1'b1, 0);

      // R10: unmapped addresses and write on a tick cycle
      cur_req = "R10"; wr(6, 'hFFFF); wr(7, 'hFFFF); run(6, 2, 1'b1, 0);
      cyc(1, 0, 1, 0, 1, 1, 2, 'h025); run(6, 1, 1'b1, 0);
      idle(3);

      @(posedge clk);
      #2;
      summary();
   end
endmodule